// File: doc/BRIEF.md
# Neighborhood Majority Defect Comparator

This block sits beside a group of SRAM columns that a memory test exercises in parallel. Each column has a current sensor that reports its consumption as a one-bit pulse-width-modulated line. During every memory operation the block counts, per column, how many sampled cycles that line was high. When the test controller marks the end of the operation, the block turns each count into a 2-bit signature code.

The codes are then put to a vote. There is no fixed current threshold. The reference is whichever code more than half of the columns share. Any column whose code differs from that reference is marked defective, whether its high time was longer or shorter than the reference. If no code wins a strict majority, the operation is treated as inconclusive and no column is marked.

Defect marks are sticky until an explicit clear. A summary output reports whether any column is marked. A test that applies five operations per row gives the block five voting windows per row.

Top module: `nbr_defect_cmp`

## Requirements
- R1: After reset, every bit of `defect` is 0 and `any_defect` is 0.
- R2: A column's count grows by one only on a cycle where both `sample` and that column's `pwm` bit are 1. A high `pwm` bit while `sample` is 0 has no effect on the signature.
- R3: The window count includes the sample taken in the `op_end` cycle. It saturates at 2^CNT_W-1 (63 by default) and restarts at 0 after the `op_end` cycle. The signature code is min(count >> CODE_SHIFT, 3), where CODE_SHIFT defaults to 2.
- R4: The reference code of a window is the code held by strictly more than N_COLS/2 columns. Columns that hold the reference are never marked.
- R5: At the clock edge where `op_end` is 1 and a reference exists, every column whose code differs from it, above or below, gets its `defect` bit set. The new bit is visible after that edge.
- R6: When no code is held by more than half of the columns (for example, a 4 to 4 split or a 3/3/2 split with eight columns), the window sets no `defect` bit.
- R7: `defect` bits are sticky. A 1 on `clear` zeroes all of them at the next edge, and it overrides any marking from the same cycle.
- R8: `any_defect` is 1 exactly when at least one `defect` bit is 1.
- R9: `defect` changes only at edges where `op_end` or `clear` is 1. In particular, a deviating column is not marked before the end of its window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear | input | 1 | Zero all defect marks |
| sample | input | 1 | Strobe that qualifies the PWM lines this cycle |
| op_end | input | 1 | Last cycle of an operation window; triggers the vote |
| pwm | input | N_COLS | One PWM current signature per column |
| defect | output | N_COLS | Sticky per-column defect marks |
| any_defect | output | 1 | OR of all defect marks |

## Verification
The bench plants one column whose high time is longer in one window and shorter in another. It expects only that column to be marked, and only from the edge that closes the deviating window. A design that voted early, or compared against a threshold, would mark too soon or mark the wrong columns.

Even splits and three-way splits must leave the marks untouched. A design that chose a plurality winner would mark half of the columns. Saturation is tested with columns driven well past 63 high samples: a wrapping counter shifts the majority and marks a healthy column. The bench also checks that unsampled high pulses are ignored, that a clear overrides a marking in the same cycle, and that a deviation in the fourth of five operations of a row appears only after that operation.

// File: rtl/nbr_cmp_pkg.sv
package nbr_cmp_pkg;

   typedef logic [1:0] sig_code_t;

   localparam int unsigned CODE_MAX = 3;

   // Quantise a high-time count into a 2-bit signature, saturating at 3.
   function automatic sig_code_t quantise(input logic [31:0] cnt, input int unsigned shift);
      logic [31:0] scaled;
      scaled = cnt >> shift;
      if (scaled > 32'(CODE_MAX)) return sig_code_t'(CODE_MAX);
      return scaled[1:0];
   endfunction

endpackage

// File: rtl/pwm_hi_counter.sv
module pwm_hi_counter
   import nbr_cmp_pkg::*;
#(
   parameter int unsigned CNT_W      = 6,
   parameter int unsigned CODE_SHIFT = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sample,
   input  logic      pwm,
   input  logic      op_end,
   output sig_code_t code
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("pwm_hi_counter: CNT_W out of range");
      end
      if (CODE_SHIFT >= CNT_W) begin : g_bad_shift
         $error("pwm_hi_counter: CODE_SHIFT must be below CNT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_win;

   // Count including this cycle's sample, saturating.
   always_comb begin
      cnt_win = cnt_q;
      if (sample && pwm && (cnt_q != CNT_MAX)) cnt_win = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (op_end)  cnt_q <= '0;
      else              cnt_q <= cnt_win;
   end

   assign code = quantise(32'(cnt_win), CODE_SHIFT);

   // R3
   no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !op_end) |=> (cnt_q == CNT_MAX));

   // R3
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_end |=> (cnt_q <= 1));

endmodule

// File: rtl/majority_voter.sv
module majority_voter
   import nbr_cmp_pkg::*;
#(
   parameter int unsigned N_COLS = 8
) (
   input  logic [2*N_COLS-1:0] codes,
   output sig_code_t           maj_code,
   output logic                maj_valid
);

   localparam int unsigned TALLY_W = $clog2(N_COLS + 1);
   localparam int unsigned N_CODES = CODE_MAX + 1;

   logic [TALLY_W-1:0] tally [N_CODES];
   logic [N_CODES-1:0] wins;

   generate
      for (genvar v = 0; v < N_CODES; v++) begin : g_val
         always_comb begin
            tally[v] = '0;
            for (int c = 0; c < N_COLS; c++) begin
               if (codes[2*c +: 2] == sig_code_t'(v)) tally[v] = tally[v] + 1'b1;
            end
            wins[v] = (32'(tally[v]) * 2) > N_COLS;
         end
      end
   endgenerate

   always_comb begin
      maj_code = '0;
      for (int v = 0; v < N_CODES; v++) begin
         if (wins[v]) maj_code = sig_code_t'(v);
      end
   end

   assign maj_valid = |wins;

   // R4: at most one code can hold a strict majority
   always_comb begin
      single_winner_chk: assert ($onehot0(wins));
   end

endmodule

// File: rtl/nbr_defect_cmp.sv
module nbr_defect_cmp
   import nbr_cmp_pkg::*;
#(
   parameter int unsigned N_COLS     = 8,
   parameter int unsigned CNT_W      = 6,
   parameter int unsigned CODE_SHIFT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              sample,
   input  logic              op_end,
   input  logic [N_COLS-1:0] pwm,
   output logic [N_COLS-1:0] defect,
   output logic              any_defect
);

   generate
      if (N_COLS < 3) begin : g_bad_cols
         $error("nbr_defect_cmp: at least three columns are needed for a vote");
      end
   endgenerate

   logic [2*N_COLS-1:0] codes;
   logic [N_COLS-1:0]   mism;
   logic [N_COLS-1:0]   flags_q;
   sig_code_t           maj_code;
   logic                maj_valid;

   generate
      for (genvar c = 0; c < N_COLS; c++) begin : g_col
         pwm_hi_counter #(
            .CNT_W      (CNT_W),
            .CODE_SHIFT (CODE_SHIFT)
         ) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .sample (sample),
            .pwm    (pwm[c]),
            .op_end (op_end),
            .code   (codes[2*c +: 2])
         );
         assign mism[c] = (codes[2*c +: 2] != maj_code);
      end
   endgenerate

   majority_voter #(.N_COLS(N_COLS)) u_vote (
      .codes     (codes),
      .maj_code  (maj_code),
      .maj_valid (maj_valid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     flags_q <= '0;
      else if (clear)                 flags_q <= '0;
      else if (op_end && maj_valid)   flags_q <= flags_q | mism;
   end

   assign defect     = flags_q;
   assign any_defect = |flags_q;

   // R6
   inconclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end && !maj_valid && !clear) |=> (defect == $past(defect)));

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((defect & $past(defect)) == $past(defect)));

   // R7
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (defect == '0));

   // R9
   quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!op_end && !clear) |=> $stable(defect));

   // R4
   minority_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_end && maj_valid && !clear) |=>
         (($countones(defect & ~$past(defect)) * 2) < N_COLS));

endmodule

// File: tb/tb_nbr_defect_cmp.sv
module tb_nbr_defect_cmp;

   localparam int NC    = 8;
   localparam int CW    = 6;
   localparam int SH    = 2;
   localparam int CMAX  = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          clear, sample, op_end;
   logic [NC-1:0] pwm;
   logic [NC-1:0] defect;
   logic          any_defect;

   int checks = 0;
   int errors = 0;

   // behavioural reference state
   int mcnt [NC];
   bit mflag [NC];

   always #4 clk = ~clk;

   nbr_defect_cmp #(.N_COLS(NC), .CNT_W(CW), .CODE_SHIFT(SH)) dut (
      .clk(clk), .rst_n(rst_n), .clear(clear), .sample(sample),
      .op_end(op_end), .pwm(pwm), .defect(defect), .any_defect(any_defect)
   );

   function automatic logic [NC-1:0] model_vec();
      logic [NC-1:0] v;
      for (int i = 0; i < NC; i++) v[i] = mflag[i];
      return v;
   endfunction

   // every-clock comparison against the reference model (R5, R8)
   task automatic compare_model();
      logic [NC-1:0] e;
      e = model_vec();
      checks++;
      if (defect !== e) begin
         errors++;
         $display("FAIL R5 model: defect actual %b expected %b", defect, e);
      end
      checks++;
      if (any_defect !== (|e)) begin
         errors++;
         $display("FAIL R8 model: any_defect actual %b expected %b", any_defect, |e);
      end
   endtask

   task automatic model_update(bit s, logic [NC-1:0] p, bit oe, bit clr);
      int code [NC];
      int hist [4];
      int maj;
      for (int v = 0; v < 4; v++) hist[v] = 0;
      for (int i = 0; i < NC; i++) begin
         if (s && p[i] && mcnt[i] < CMAX) mcnt[i]++;
         code[i] = (mcnt[i] >> SH) > 3 ? 3 : (mcnt[i] >> SH);
         hist[code[i]]++;
      end
      maj = -1;
      for (int v = 0; v < 4; v++) if (hist[v] * 2 > NC) maj = v;
      if (clr) begin
         for (int i = 0; i < NC; i++) mflag[i] = 1'b0;
      end else if (oe && maj >= 0) begin
         for (int i = 0; i < NC; i++) if (code[i] != maj) mflag[i] = 1'b1;
      end
      if (oe) for (int i = 0; i < NC; i++) mcnt[i] = 0;
   endtask

   task automatic step(bit s, logic [NC-1:0] p, bit oe, bit clr);
      @(negedge clk);
      compare_model();
      sample = s; pwm = p; op_end = oe; clear = clr;
      @(posedge clk);
      model_update(s, p, oe, clr);
      #1;
      sample = 1'b0; op_end = 1'b0; clear = 1'b0; pwm = '0;
   endtask

   // One window of len sampled cycles; column i is high for its first hi[i] samples.
   task automatic run_window(int hi [NC], int len, int idle_col, bit clr_at_end);
      logic [NC-1:0] p;
      if (idle_col >= 0) begin
         for (int k = 0; k < 6; k++) step(1'b0, NC'(1) << idle_col, 1'b0, 1'b0);
      end
      for (int t = 0; t < len; t++) begin
         for (int i = 0; i < NC; i++) p[i] = (t < hi[i]);
         step(1'b1, p, (t == len - 1), clr_at_end && (t == len - 1));
      end
   endtask

   task automatic expect_flags(logic [NC-1:0] e, string tag);
      @(negedge clk);
      checks++;
      if (defect !== e || any_defect !== (|e)) begin
         errors++;
         $display("FAIL %s: defect actual %b/%b expected %b/%b", tag, defect, any_defect, e, |e);
      end
   endtask

   task automatic set_all(ref int hi [NC], input int v);
      for (int i = 0; i < NC; i++) hi[i] = v;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int hi [NC];
      rst_n = 1'b0; clear = 1'b0; sample = 1'b0; op_end = 1'b0; pwm = '0;
      for (int i = 0; i < NC; i++) begin mcnt[i] = 0; mflag[i] = 1'b0; end
      repeat (3) @(posedge clk);
      // R1: reset state
      expect_flags('0, "R1 reset");
      @(negedge clk) rst_n = 1'b1;

      // R4: uniform window, no marks
      set_all(hi, 8);
      run_window(hi, 8, -1, 1'b0);
      expect_flags('0, "R4 uniform");

      // R9 and R5: column 3 longer; no mark before window end
      set_all(hi, 8); hi[3] = 12;
      for (int t = 0; t < 11; t++) step(1'b1, (t < 8) ? '1 : NC'(8), 1'b0, 1'b0);
      expect_flags('0, "R9 mid-window");
      step(1'b1, NC'(8), 1'b1, 1'b0);
      expect_flags(NC'(8), "R5 longer high time");

      // R5 and R7: column 5 shorter; column 3 stays marked
      set_all(hi, 8); hi[5] = 4;
      run_window(hi, 8, -1, 1'b0);
      expect_flags(NC'(8'h28), "R7 sticky plus R5 shorter");

      // R7: clear
      step(1'b0, '0, 1'b0, 1'b1);
      expect_flags('0, "R7 clear");

      // R7: clear beats a same-cycle marking
      set_all(hi, 8); hi[0] = 0;
      run_window(hi, 8, -1, 1'b1);
      expect_flags('0, "R7 clear priority");

      // R6: 4/4 tie
      set_all(hi, 8); hi[4] = 4; hi[5] = 4; hi[6] = 4; hi[7] = 4;
      run_window(hi, 8, -1, 1'b0);
      expect_flags('0, "R6 even split");

      // R6: 3/3/2 split
      set_all(hi, 8); hi[3] = 4; hi[4] = 4; hi[5] = 4; hi[6] = 0; hi[7] = 0;
      run_window(hi, 8, -1, 1'b0);
      expect_flags('0, "R6 three-way split");

      // R2: unsampled high pulses on column 1 ignored
      set_all(hi, 8);
      run_window(hi, 8, 1, 1'b0);
      expect_flags('0, "R2 unsampled pulses");

      // R3: saturation; seven columns 70 highs, column 2 fifteen highs (both code 3)
      set_all(hi, 70); hi[2] = 15;
      run_window(hi, 70, -1, 1'b0);
      expect_flags('0, "R3 saturation");

      // R3: restart at zero; 4 highs gives code 1 for all, column 6 at 8 gives code 2
      set_all(hi, 4); hi[6] = 8;
      run_window(hi, 8, -1, 1'b0);
      expect_flags(NC'(8'h40), "R3 restart and code");
      step(1'b0, '0, 1'b0, 1'b1);

      // R5 and R9: row of five operations, column 6 deviates only in the fourth
      for (int op = 0; op < 5; op++) begin
         set_all(hi, 8);
         if (op == 3) hi[6] = 2;
         run_window(hi, 8, -1, 1'b0);
         expect_flags((op >= 3) ? NC'(8'h40) : '0, "R9 row of five operations");
      end

      // R8: summary follows the marks
      @(negedge clk);
      checks++;
      if (any_defect !== 1'b1) begin
         errors++;
         $display("FAIL R8 summary: actual %b expected 1", any_defect);
      end
      step(1'b0, '0, 1'b0, 1'b0);
      @(negedge clk);
      compare_model();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule